// File: doc/BRIEF.md
# Dual-Width Static Memory Lane Steering Decoder

This block models the device side of an asynchronous static memory whose bus is normally 16 bits wide and can also run 8 bits wide. Each cycle it takes the two chip selects (one active low, one active high), the width select, the two byte-lane strobes, write enable and output enable. It decodes them into a single operation: standby, output disable, lower, upper or full word read or write, or a narrow (8-bit) read or write. From that operation it drives the tri-state enables of the two byte lanes and routes the data between the pins and the storage.

In narrow mode the top data input is used as the lowest address bit. The byte address is then the word address with that bit appended, where 0 picks the low byte of the word and 1 the high byte. The storage is two equal register banks chosen by the top word-address bit. Its depth is a parameter, so a small array keeps the same bit mapping. Reads are combinational from the pins. Writes are committed on the rising clock edge while a write operation is decoded.

Top module: `lane_steer_sram`

## Requirements
- R1: While `sel_n` is 1 or `sel` is 0, neither lane enable (`dq_oe_lo`, `dq_oe_hi`) is driven, `proto_err` is 0 and no write takes place, whatever the other pins do (this includes narrow mode with a strobe high).
- R2: In word mode (`narrow_n` = 1) with both strobes `lane_lo_n` and `lane_hi_n` at 1, nothing is driven and no write takes place.
- R3: A word-mode read with only `lane_lo_n` low (`wr_n` = 1, `out_en_n` = 0) drives `dq_oe_lo` only, and `dq_o[7:0]` carries bits 7:0 of the addressed word.
- R4: A word-mode read with only `lane_hi_n` low drives `dq_oe_hi` only, with `dq_o[15:8]` = bits 15:8 of the word. With both strobes low, both lanes are driven with the whole word.
- R5: With the chip selected and `wr_n` = 1, `out_en_n` = 1, no lane is driven, whatever the strobes are.
- R6: With `wr_n` = 0, no lane is driven even if `out_en_n` = 0. In word mode a low `lane_lo_n` writes `dq_i[7:0]` into bits 7:0 and a low `lane_hi_n` writes `dq_i[15:8]` into bits 15:8, and a lane whose strobe is high keeps its old contents.
- R7: In narrow mode (`narrow_n` = 0, both strobes low), `dq_i[15]` is the lowest byte-address bit: 0 selects bits 7:0 of the word at `waddr`, and 1 selects bits 15:8. A narrow write stores `dq_i[7:0]` into the selected byte only. A narrow read drives `dq_oe_lo` only, with the selected byte on `dq_o[7:0]`. `dq_oe_hi` is never driven in narrow mode.
- R8: Selected and in narrow mode with either strobe at 1, `proto_err` is 1, no lane is driven and no write takes place. Otherwise `proto_err` is 0.
- R9: The word address `waddr` has `AW` bits. Its top bit picks one of two banks and the lower bits pick the word inside it, so words that differ only in the top bit are independent.
- R10: A synchronous active-high reset clears every stored word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears storage |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| narrow_n | input | 1 | 0 selects 8-bit mode |
| lane_lo_n | input | 1 | Active-low strobe for bits 7:0 |
| lane_hi_n | input | 1 | Active-low strobe for bits 15:8 |
| wr_n | input | 1 | Active-low write enable |
| out_en_n | input | 1 | Active-low output enable |
| waddr | input | AW | Word address; top bit selects bank |
| dq_i | input | 16 | Data from the pins; bit 15 is the low byte-address bit in narrow mode |
| dq_o | output | 16 | Data toward the pins |
| dq_oe_lo | output | 1 | Drive enable for pins 7:0 |
| dq_oe_hi | output | 1 | Drive enable for pins 15:8 |
| proto_err | output | 1 | Narrow mode used with a strobe high |

## Verification
The operation decode is tried with deselects of each polarity while write is asserted, with both strobes high and write low, and with each single strobe and both strobes for reads and writes. A partial write followed by a full read shows that a lane really was preserved rather than rewritten. Narrow accesses with the byte-address bit at 0 and then 1 on the same word tell a correct byte pick apart from a swapped one. Protocol-error accesses and writes into the other bank are each followed by reads that show nothing was corrupted.

// File: rtl/sram_ls_pkg.sv
package sram_ls_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [3:0] {
        OP_STANDBY,
        OP_OUT_DIS,
        OP_RD_LO,
        OP_RD_HI,
        OP_RD_WORD,
        OP_WR_LO,
        OP_WR_HI,
        OP_WR_WORD,
        OP_RD_BYTE,
        OP_WR_BYTE,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic narrow_n;
        logic lo_n;
        logic hi_n;
        logic wr_n;
        logic oe_n;
        logic am1;
    } pins_t;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lane_we;
        logic             drv_lo;
        logic             drv_hi;
        logic             narrow;
        logic             hi_byte;
        logic             err;
    } ctl_t;

    function automatic op_e classify(pins_t p);
        op_e r;
        if (p.sel_n || !p.sel) begin
            r = OP_STANDBY;
        end else if (!p.narrow_n) begin
            if (p.lo_n || p.hi_n)  r = OP_BAD;
            else if (!p.wr_n)      r = OP_WR_BYTE;
            else if (!p.oe_n)      r = OP_RD_BYTE;
            else                   r = OP_OUT_DIS;
        end else if (p.lo_n && p.hi_n) begin
            r = OP_STANDBY;
        end else if (!p.wr_n) begin
            if (p.hi_n)            r = OP_WR_LO;
            else if (p.lo_n)       r = OP_WR_HI;
            else                   r = OP_WR_WORD;
        end else if (!p.oe_n) begin
            if (p.hi_n)            r = OP_RD_LO;
            else if (p.lo_n)       r = OP_RD_HI;
            else                   r = OP_RD_WORD;
        end else begin
            r = OP_OUT_DIS;
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_ls_decode.sv
module sram_ls_decode
    import sram_ls_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output ctl_t  ctl
);

    op_e op;

    always_comb begin
        op          = classify(pins);
        ctl         = '0;
        ctl.op      = op;
        ctl.narrow  = !pins.narrow_n;
        ctl.hi_byte = pins.am1;
        case (op)
            OP_RD_LO:   ctl.drv_lo = 1'b1;
            OP_RD_HI:   ctl.drv_hi = 1'b1;
            OP_RD_WORD: begin
                ctl.drv_lo = 1'b1;
                ctl.drv_hi = 1'b1;
            end
            OP_RD_BYTE: ctl.drv_lo = 1'b1;
            OP_WR_LO:   ctl.lane_we = 2'b01;
            OP_WR_HI:   ctl.lane_we = 2'b10;
            OP_WR_WORD: ctl.lane_we = 2'b11;
            OP_WR_BYTE: ctl.lane_we = pins.am1 ? 2'b10 : 2'b01;
            OP_BAD:     ctl.err = 1'b1;
            default:    ;
        endcase
    end

    // R8: a protocol error never lets a write or a drive through
    a_r8_err_blocks_access: assert property (@(posedge clk) disable iff (rst)
        ctl.err |-> (ctl.lane_we == '0) && !ctl.drv_lo && !ctl.drv_hi);

    // R6: no operation both writes and drives
    a_r6_write_not_read: assert property (@(posedge clk) disable iff (rst)
        (ctl.lane_we != '0) |-> !ctl.drv_lo && !ctl.drv_hi);

    // R7: a narrow write touches exactly one lane
    a_r7_narrow_one_lane: assert property (@(posedge clk) disable iff (rst)
        (ctl.narrow && (ctl.lane_we != '0)) |-> $countones(ctl.lane_we) == 1);

endmodule

// File: rtl/sram_ls_bank.sv
module sram_ls_bank
    import sram_ls_pkg::*;
#(
    parameter int ABITS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  we,
    input  logic [ABITS-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ABITS;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end

    // R10: the cycle after reset every word reads back as zero
    a_r10_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rdata == '0);

endmodule

// File: rtl/sram_ls_steer.sv
module sram_ls_steer
    import sram_ls_pkg::*;
(
    input  logic              narrow,
    input  logic              hi_byte,
    input  logic [DATA_W-1:0] dq_i,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dq_o
);

    always_comb begin
        if (narrow) begin
            wdata = {LANES{dq_i[LANE_W-1:0]}};
            dq_o  = '0;
            dq_o[LANE_W-1:0] = hi_byte ? rword[DATA_W-1 -: LANE_W]
                                       : rword[LANE_W-1:0];
        end else begin
            wdata = dq_i;
            dq_o  = rword;
        end
    end

endmodule

// File: rtl/lane_steer_sram.sv
module lane_steer_sram
    import sram_ls_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_n,
    input  logic          sel,
    input  logic          narrow_n,
    input  logic          lane_lo_n,
    input  logic          lane_hi_n,
    input  logic          wr_n,
    input  logic          out_en_n,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   dq_i,
    output logic [15:0]   dq_o,
    output logic          dq_oe_lo,
    output logic          dq_oe_hi,
    output logic          proto_err
);

    localparam int BANKS = 2;
    localparam int BA    = AW - 1;

    pins_t             pins;
    ctl_t              ctl;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] bank_rd [BANKS];

    assign pins = '{sel_n: sel_n, sel: sel, narrow_n: narrow_n,
                    lo_n: lane_lo_n, hi_n: lane_hi_n, wr_n: wr_n,
                    oe_n: out_en_n, am1: dq_i[DATA_W-1]};

    sram_ls_decode i_decode (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .ctl  (ctl)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [LANES-1:0] bwe;
        assign bwe = (waddr[AW-1] == b[0]) ? ctl.lane_we : '0;

        sram_ls_bank #(.ABITS(BA)) i_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (bwe),
            .addr  (waddr[BA-1:0]),
            .wdata (wdata),
            .rdata (bank_rd[b])
        );
    end

    assign rword = bank_rd[waddr[AW-1]];

    sram_ls_steer i_steer (
        .narrow  (ctl.narrow),
        .hi_byte (ctl.hi_byte),
        .dq_i    (dq_i),
        .rword   (rword),
        .wdata   (wdata),
        .dq_o    (dq_o)
    );

    assign dq_oe_lo  = ctl.drv_lo;
    assign dq_oe_hi  = ctl.drv_hi;
    assign proto_err = ctl.err;

    // R1: deselected means quiet pins and no error
    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel_n || !sel) |-> !dq_oe_lo && !dq_oe_hi && !proto_err);

    // R6: write enable wins over output enable
    a_r6_write_inputs: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> !dq_oe_lo && !dq_oe_hi);

    // R5: output disable whatever the strobes
    a_r5_output_disable: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && sel && wr_n && out_en_n) |-> !dq_oe_lo && !dq_oe_hi);

    // R7: upper pins never driven in narrow mode
    a_r7_narrow_hi_quiet: assert property (@(posedge clk) disable iff (rst)
        !narrow_n |-> !dq_oe_hi);

    // R8: error flag only on the bad-strobe operation, with nothing driven
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !dq_oe_lo && !dq_oe_hi && (ctl.op == OP_BAD) && !narrow_n);

    // R3: lower lane alone is driven only for a low-strobe read
    a_r3_lo_only: assert property (@(posedge clk) disable iff (rst)
        (dq_oe_lo && !dq_oe_hi && narrow_n) |-> !lane_lo_n && lane_hi_n);

endmodule

// File: tb/test_lane_steer_sram.sv
module test_lane_steer_sram;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, sel = 1'b0, narrow_n = 1'b1;
    logic          lane_lo_n = 1'b1, lane_hi_n = 1'b1, wr_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] waddr = '0;
    logic [15:0]   dq_i = '0;
    logic [15:0]   dq_o;
    logic          dq_oe_lo, dq_oe_hi, proto_err;

    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;
    logic [15:0] ref_mem [WORDS];

    always #2 clk = ~clk;

    lane_steer_sram #(.AW(AW)) i_lane_steer_sram (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .narrow_n(narrow_n),
        .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .wr_n(wr_n),
        .out_en_n(out_en_n), .waddr(waddr), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .proto_err(proto_err)
    );

    task automatic step(input string tag, input logic sn, input logic s,
                        input logic nn, input logic ln, input logic hn,
                        input logic wn, input logic on,
                        input logic [AW-1:0] a, input logic [15:0] d);
        bit act, nar, e_err, e_lo, e_hi, ok;
        bit [1:0] ew;
        logic [15:0] w, e_d;
        @(negedge clk);
        sel_n = sn; sel = s; narrow_n = nn; lane_lo_n = ln; lane_hi_n = hn;
        wr_n = wn; out_en_n = on; waddr = a; dq_i = d;
        #1;
        act = !sn && s; nar = !nn;
        e_err = act && nar && (ln || hn);
        e_lo = 0; e_hi = 0; ew = 2'b00; e_d = '0;
        w = ref_mem[a];
        if (act && !e_err) begin
            if (nar) begin
                if (!wn)      ew = d[15] ? 2'b10 : 2'b01;
                else if (!on) begin
                    e_lo = 1;
                    e_d[7:0] = d[15] ? w[15:8] : w[7:0];
                end
            end else if (!(ln && hn)) begin
                if (!wn)      ew = {!hn, !ln};
                else if (!on) begin
                    e_lo = !ln; e_hi = !hn; e_d = w;
                end
            end
        end
        ok = (dq_oe_lo == e_lo) && (dq_oe_hi == e_hi) && (proto_err == e_err)
             && (!e_lo || dq_o[7:0] == e_d[7:0]) && (!e_hi || dq_o[15:8] == e_d[15:8]);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: oe_lo=%0b oe_hi=%0b err=%0b dq_o=%h expected oe_lo=%0b oe_hi=%0b err=%0b dq_o=%h",
                     tag, dq_oe_lo, dq_oe_hi, proto_err, dq_o, e_lo, e_hi, e_err, e_d);
        end
        @(posedge clk);
        if (ew[0]) ref_mem[a][7:0]  = d[7:0];
        if (ew[1]) ref_mem[a][15:8] = nar ? d[7:0] : d[15:8];
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        step("R10", 0, 1, 1, 0, 0, 1, 0, 6'd5,  16'h0);
        step("R10", 0, 1, 1, 0, 0, 1, 0, 6'd40, 16'h0);
        // R1 deselect of each polarity with write low
        step("R1",  1, 1, 1, 0, 0, 0, 0, 6'd3, 16'hDEAD);
        step("R1",  0, 0, 1, 0, 0, 0, 0, 6'd3, 16'hBEEF);
        step("R1",  1, 1, 0, 1, 0, 0, 0, 6'd3, 16'h1234);
        step("R1",  0, 1, 1, 0, 0, 1, 0, 6'd3, 16'h0);
        // R6 full word write with output enable also low
        step("R6",  0, 1, 1, 0, 0, 0, 0, 6'd3, 16'hA5C3);
        step("R4",  0, 1, 1, 0, 0, 1, 0, 6'd3, 16'h0);
        // R2 both strobes high, write attempt
        step("R2",  0, 1, 1, 1, 1, 0, 0, 6'd3, 16'hFFFF);
        step("R2",  0, 1, 1, 1, 1, 1, 0, 6'd3, 16'h0);
        step("R4",  0, 1, 1, 0, 0, 1, 0, 6'd3, 16'h0);
        // R6 partial writes preserve the other lane
        step("R6",  0, 1, 1, 0, 1, 0, 1, 6'd3, 16'h1111);
        step("R6",  0, 1, 1, 1, 0, 0, 1, 6'd3, 16'h2200);
        step("R4",  0, 1, 1, 0, 0, 1, 0, 6'd3, 16'h0);
        // R3 / R4 single-lane reads
        step("R3",  0, 1, 1, 0, 1, 1, 0, 6'd3, 16'h0);
        step("R4",  0, 1, 1, 1, 0, 1, 0, 6'd3, 16'h0);
        // R5 output disable with each strobe pattern
        step("R5",  0, 1, 1, 0, 0, 1, 1, 6'd3, 16'h0);
        step("R5",  0, 1, 1, 0, 1, 1, 1, 6'd3, 16'h0);
        step("R5",  0, 1, 1, 1, 0, 1, 1, 6'd3, 16'h0);
        // R9 other bank
        step("R9",  0, 1, 1, 0, 0, 0, 1, 6'd35, 16'h7777);
        step("R9",  0, 1, 1, 0, 0, 1, 0, 6'd3,  16'h0);
        step("R9",  0, 1, 1, 0, 0, 1, 0, 6'd35, 16'h0);
        step("R9",  0, 1, 1, 0, 0, 1, 0, 6'd63, 16'h0);
        // R7 narrow writes and reads on word 10
        step("R7",  0, 1, 0, 0, 0, 0, 1, 6'd10, 16'h5A3C);
        step("R7",  0, 1, 0, 0, 0, 0, 0, 6'd10, 16'hA5C3);
        step("R7",  0, 1, 1, 0, 0, 1, 0, 6'd10, 16'h0);
        step("R7",  0, 1, 0, 0, 0, 1, 0, 6'd10, 16'h0000);
        step("R7",  0, 1, 0, 0, 0, 1, 0, 6'd10, 16'h8000);
        step("R7",  0, 1, 0, 0, 0, 1, 1, 6'd10, 16'h8000);
        // R8 bad strobes in narrow mode
        step("R8",  0, 1, 0, 0, 1, 0, 0, 6'd10, 16'h80FF);
        step("R8",  0, 1, 0, 1, 0, 0, 0, 6'd10, 16'h00EE);
        step("R8",  0, 1, 0, 1, 1, 1, 0, 6'd10, 16'h0);
        step("R8",  0, 1, 1, 0, 0, 1, 0, 6'd10, 16'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule